// File: doc/BRIEF.md
# PLL Dynamic Phase-Shift Sequencer

This block sits between user logic and the dynamic phase-adjust pins of a PLL. User logic hands it one request at a time: which clock output to shift, whether the shift lags or leads, the shift mode and a step count. The sequencer then drives the PLL's output-select and direction lines. It waits out a setup interval and issues the requested number of strobe pulses. Each pulse respects the minimum high and low widths the PLL needs.

There are two modes, and each has its own strobe. In fine mode, each pulse of the fine strobe moves the chosen output by one VCO step of 360/(8*DIV) degrees. Its high and low widths are each at least four VCO periods. In coarse mode, each pulse of the load strobe reloads the post-divider phase, which gives a shift of ((CPHASE-DIV)/(DIV+1))*360 degrees. That pulse must be at least 10 ns wide, and a divider-dependent settling gap must pass before the next load.

All intervals are given as parameters in picoseconds, together with the sequencer clock period. Each is rounded up to a whole number of clock cycles, with a floor of one cycle, so every minimum holds.

Top module: `phase_step_seq`

## Requirements
- R1: After reset, both strobes are low, `done` is low, `req_ready` is high, and `pll_sel` and `pll_dir` are zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `pll_sel`/`pll_dir` show the request's select and direction, and they hold those values until the next accepted request.
- R3: For a nonzero step count, the first strobe pulse rises after `pll_sel`/`pll_dir` have been stable for SETUP cycles, where SETUP = ceil(SETUP_PS/CLK_PS) with a minimum of 1.
- R4: When `req_mode`=0 (fine), the block issues exactly `req_steps` pulses on `fine_strobe`, each high for ceil(VCO_MULT*VCO_PS/CLK_PS) cycles.
- R5: In fine mode, each fine pulse, including the last, is followed by a low time of ceil(VCO_MULT*VCO_PS/CLK_PS) cycles.
- R6: When `req_mode`=1 (coarse), the block issues exactly `req_steps` pulses on `load_strobe`, each high for ceil(LOAD_PS/CLK_PS) cycles.
- R7: In coarse mode, each load pulse, including the last, is followed by a recovery gap of ceil(RECOV_PS/CLK_PS) cycles.
- R8: `req_ready` stays low from the cycle after acceptance until the request completes. A `req_valid` presented during that time is ignored and changes neither the outputs nor the pulse train.
- R9: `done` is high for exactly one cycle, in the cycle where `req_ready` returns high. For a nonzero count this is SETUP + steps*(high+low) cycles after the cycle that follows acceptance.
- R10: A request with a step count of zero raises `done` and `req_ready` in the cycle right after acceptance, and neither strobe pulses.
- R11: `fine_strobe` and `load_strobe` are never high in the same cycle, and the strobe of the mode that was not requested stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_sel | input | 2 | Clock output to shift |
| req_dir | input | 1 | 0 = lag, 1 = lead |
| req_mode | input | 1 | 0 = fine VCO step, 1 = coarse divider load |
| req_steps | input | CNT_W | Number of pulses to issue |
| pll_sel | output | 2 | Output-select lines to the PLL |
| pll_dir | output | 1 | Direction line to the PLL |
| fine_strobe | output | 1 | Fine-step strobe to the PLL |
| load_strobe | output | 1 | Divider-load strobe to the PLL |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sends fine requests with counts of one and several, and coarse requests with counts of one and several. Each request uses different select and direction values. For every cycle it compares both strobes against an expected waveform. This separates a wrong setup delay from a wrong high width or a wrong low or recovery width, and it shows if the mode-to-strobe mapping is swapped. A request with a count of zero checks the immediate-completion path. A second request held valid while a run is in progress checks that a busy sequencer ignores new input. Checking `pll_sel`/`pll_dir` after completion confirms that they keep their values.

// File: rtl/phs_pkg.sv
package phs_pkg;

    typedef enum logic {
        MODE_FINE   = 1'b0,
        MODE_COARSE = 1'b1
    } phs_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } phs_state_e;

    typedef enum logic [1:0] {
        IV_SETUP = 2'd0,
        IV_HIGH  = 2'd1,
        IV_LOW   = 2'd2
    } phs_interval_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       dir;
        phs_mode_e  mode;
    } phs_req_t;

    // Rounds a time in ps up to whole clock cycles, never below one.
    function automatic int unsigned cyc_ceil(input int unsigned ps, input int unsigned clk_ps);
        int unsigned c;
        c = (ps + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/phs_interval_timer.sv
module phs_interval_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/phs_step_counter.sv
module phs_step_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == W'(1));
endmodule

// File: rtl/phs_ctrl_fsm.sv
module phs_ctrl_fsm
    import phs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          zero_cnt,
    input  logic          tmr_expired,
    input  logic          last_step,
    output phs_state_e    state,
    output logic          tmr_load,
    output phs_interval_e tmr_kind,
    output logic          cnt_load,
    output logic          cnt_dec,
    output logic          done
);
    phs_state_e state_q, state_d;
    logic       done_q, done_d;

    always_comb begin
        state_d  = state_q;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_kind = IV_SETUP;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (zero_cnt) begin
                        done_d = 1'b1;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_kind = IV_SETUP;
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_kind = IV_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_kind = IV_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    if (last_step) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        state_d  = ST_HIGH;
                        tmr_load = 1'b1;
                        tmr_kind = IV_HIGH;
                        cnt_dec  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign state = state_q;
    assign done  = done_q;
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq
    import phs_pkg::*;
#(
    parameter int unsigned CLK_PS   = 10000,
    parameter int unsigned SETUP_PS = 5000,
    parameter int unsigned VCO_PS   = 4000,
    parameter int unsigned VCO_MULT = 4,
    parameter int unsigned LOAD_PS  = 10000,
    parameter int unsigned RECOV_PS = 45000,
    parameter int unsigned CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_sel,
    input  logic             req_dir,
    input  logic             req_mode,
    input  logic [CNT_W-1:0] req_steps,
    output logic [1:0]       pll_sel,
    output logic             pll_dir,
    output logic             fine_strobe,
    output logic             load_strobe,
    output logic             done
);
    localparam int unsigned SETUP_C = cyc_ceil(SETUP_PS, CLK_PS);
    localparam int unsigned FINE_C  = cyc_ceil(VCO_MULT * VCO_PS, CLK_PS);
    localparam int unsigned LOAD_C  = cyc_ceil(LOAD_PS, CLK_PS);
    localparam int unsigned RECOV_C = cyc_ceil(RECOV_PS, CLK_PS);
    localparam int unsigned MAX_C   = max2(max2(SETUP_C, FINE_C), max2(LOAD_C, RECOV_C));
    localparam int unsigned TMR_W   = $clog2(MAX_C + 1);

    phs_req_t      req_q;
    phs_state_e    state;
    phs_interval_e tmr_kind;
    logic          accept, tmr_load, tmr_expired, cnt_load, cnt_dec, last_step;
    logic [TMR_W-1:0] tmr_val;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Request register: PLL-facing select and direction hold until next accept.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{sel: 2'b00, dir: 1'b0, mode: MODE_FINE};
        end else if (accept) begin
            req_q <= '{sel: req_sel, dir: req_dir, mode: phs_mode_e'(req_mode)};
        end
    end

    // Interval length per phase and mode, minus one for the down-counter.
    always_comb begin
        unique case (tmr_kind)
            IV_HIGH: tmr_val = (req_q.mode == MODE_FINE) ? TMR_W'(FINE_C - 1) : TMR_W'(LOAD_C - 1);
            IV_LOW:  tmr_val = (req_q.mode == MODE_FINE) ? TMR_W'(FINE_C - 1) : TMR_W'(RECOV_C - 1);
            default: tmr_val = TMR_W'(SETUP_C - 1);
        endcase
    end

    phs_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .zero_cnt    (req_steps == '0),
        .tmr_expired (tmr_expired),
        .last_step   (last_step),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_kind    (tmr_kind),
        .cnt_load    (cnt_load),
        .cnt_dec     (cnt_dec),
        .done        (done)
    );

    phs_interval_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    phs_step_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (req_steps),
        .dec      (cnt_dec),
        .last     (last_step)
    );

    // One strobe per mode; the unused one stays low.
    logic [1:0] strobe_vec;
    for (genvar m = 0; m < 2; m++) begin : g_strobe
        assign strobe_vec[m] = (state == ST_HIGH) && (req_q.mode == phs_mode_e'(m));
    end

    assign fine_strobe = strobe_vec[MODE_FINE];
    assign load_strobe = strobe_vec[MODE_COARSE];
    assign pll_sel     = req_q.sel;
    assign pll_dir     = req_q.dir;
endmodule

// File: rtl/phs_seq_chk.sv
module phs_seq_chk
    import phs_pkg::*;
#(
    parameter int unsigned CLK_PS   = 10000,
    parameter int unsigned SETUP_PS = 5000,
    parameter int unsigned VCO_PS   = 4000,
    parameter int unsigned VCO_MULT = 4,
    parameter int unsigned LOAD_PS  = 10000,
    parameter int unsigned RECOV_PS = 45000
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic [1:0] pll_sel,
    input logic       pll_dir,
    input logic       fine_strobe,
    input logic       load_strobe,
    input logic       done
);
    localparam int unsigned FINE_C  = cyc_ceil(VCO_MULT * VCO_PS, CLK_PS);
    localparam int unsigned LOAD_C  = cyc_ceil(LOAD_PS, CLK_PS);
    localparam int unsigned RECOV_C = cyc_ceil(RECOV_PS, CLK_PS);

    logic [7:0] fine_run, fine_gap, load_run, load_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            fine_run <= '0;
            load_run <= '0;
            fine_gap <= '1;
            load_gap <= '1;
        end else begin
            fine_run <= fine_strobe ? ((fine_run == '1) ? fine_run : fine_run + 1'b1) : '0;
            load_run <= load_strobe ? ((load_run == '1) ? load_run : load_run + 1'b1) : '0;
            fine_gap <= fine_strobe ? '0 : ((fine_gap == '1) ? fine_gap : fine_gap + 1'b1);
            load_gap <= load_strobe ? '0 : ((load_gap == '1) ? load_gap : load_gap + 1'b1);
        end
    end

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !(fine_strobe && load_strobe));

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> ($stable(pll_sel) && $stable(pll_dir)));

    p_fine_hi_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(fine_strobe) |-> (fine_run >= 8'(FINE_C)));

    p_fine_lo_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fine_strobe) |-> (fine_gap >= 8'(FINE_C)));

    p_load_hi_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(load_strobe) |-> (load_run >= 8'(LOAD_C)));

    p_load_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(load_strobe) |-> (load_gap >= 8'(RECOV_C)));

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (fine_strobe || load_strobe) |-> !req_ready);

    p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ready_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);
endmodule

bind phase_step_seq phs_seq_chk #(
    .CLK_PS   (CLK_PS),
    .SETUP_PS (SETUP_PS),
    .VCO_PS   (VCO_PS),
    .VCO_MULT (VCO_MULT),
    .LOAD_PS  (LOAD_PS),
    .RECOV_PS (RECOV_PS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .pll_sel     (pll_sel),
    .pll_dir     (pll_dir),
    .fine_strobe (fine_strobe),
    .load_strobe (load_strobe),
    .done        (done)
);

// File: tb/phase_step_seq_tb.sv
module phase_step_seq_tb;
    localparam int CLK_PS = 10000;
    localparam int CNT_W  = 8;
    // Expected cycle counts, rounded up from the ps parameters below.
    localparam int S  = 1;   // ceil(5000/10000)
    localparam int FH = 2;   // ceil(4*4000/10000)
    localparam int FL = 2;
    localparam int CH = 1;   // ceil(10000/10000)
    localparam int CL = 5;   // ceil(45000/10000)

    logic clk = 1'b0;
    logic rst, req_valid, req_ready, req_dir, req_mode;
    logic [1:0] req_sel, pll_sel;
    logic [CNT_W-1:0] req_steps;
    logic pll_dir, fine_strobe, load_strobe, done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5ns clk = ~clk;

    phase_step_seq #(
        .CLK_PS(CLK_PS), .SETUP_PS(5000), .VCO_PS(4000), .VCO_MULT(4),
        .LOAD_PS(10000), .RECOV_PS(45000), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_dir(req_dir), .req_mode(req_mode),
        .req_steps(req_steps), .pll_sel(pll_sel), .pll_dir(pll_dir),
        .fine_strobe(fine_strobe), .load_strobe(load_strobe), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_sel = 2'b00; req_dir = 1'b0;
        req_mode = 1'b0; req_steps = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(!fine_strobe && !load_strobe, "R1 strobes low", {fine_strobe, load_strobe}, 0);
        check(req_ready && !done, "R1 ready high done low", {req_ready, done}, 2);
        check(pll_sel == 2'b00 && !pll_dir, "R1 sel/dir zero", {pll_sel, pll_dir}, 0);
    endtask

    // Issues one request and compares every following cycle to the expected waveform.
    task automatic run_req(input logic [1:0] sel, input logic dir, input logic mode,
                           input int n, input bit poke);
        int hi, lo, t;
        int e_setup, e_hi, e_lo, e_other, e_done, e_rdy, e_sel;
        string ra, rb;
        hi = mode ? CH : FH;
        lo = mode ? CL : FL;
        t  = (n == 0) ? 1 : S + n * (hi + lo) + 1;
        ra = mode ? "R6" : "R4";
        rb = mode ? "R7" : "R5";
        e_setup = 0; e_hi = 0; e_lo = 0; e_other = 0; e_done = 0; e_rdy = 0; e_sel = 0;
        check(req_ready, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_sel = sel; req_dir = dir; req_mode = mode; req_steps = CNT_W'(n);
        @(negedge clk);
        if (poke) begin
            req_sel = ~sel; req_dir = ~dir; req_mode = ~mode; req_steps = 8'd3;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 1; c <= t + 2; c++) begin
            logic act, oth, exp_s;
            int k;
            act = mode ? load_strobe : fine_strobe;
            oth = mode ? fine_strobe : load_strobe;
            k = c - 1 - S;
            exp_s = (n != 0) && (k >= 0) && (k < n * (hi + lo)) && ((k % (hi + lo)) < hi);
            if (act != exp_s) begin
                if (k < 0) e_setup++;
                else if (exp_s) e_hi++;
                else e_lo++;
            end
            if (oth) e_other++;
            if (done != (c == t)) e_done++;
            if (req_ready != (c >= t)) e_rdy++;
            if (pll_sel != sel || pll_dir != dir) e_sel++;
            if (c == t - 1) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (n == 0) begin
            check(e_setup + e_hi + e_lo + e_other == 0, "R10 no strobe on zero count",
                  e_setup + e_hi + e_lo + e_other, 0);
            check(e_done + e_rdy == 0, "R10 immediate done/ready", e_done + e_rdy, 0);
        end else begin
            check(e_setup == 0, "R3 setup before first pulse", e_setup, 0);
            check(e_hi == 0, {ra, " pulse high width/count"}, e_hi, 0);
            check(e_lo == 0, {rb, " low/recovery gap"}, e_lo, 0);
            check(e_done == 0, "R9 done timing", e_done, 0);
            check(e_rdy == 0, poke ? "R8 busy request ignored" : "R8 ready low while busy", e_rdy, 0);
        end
        check(e_other == 0, "R11 other strobe idle", e_other, 0);
        check(e_sel == 0, poke ? "R8 sel/dir unchanged by busy request" : "R2 sel/dir latched and held",
              e_sel, 0);
    endtask

    task automatic t_fine_single();  run_req(2'b00, 1'b0, 1'b0, 1, 1'b0); endtask
    task automatic t_fine_multi();   run_req(2'b01, 1'b1, 1'b0, 4, 1'b0); endtask
    task automatic t_coarse_single(); run_req(2'b10, 1'b1, 1'b1, 1, 1'b0); endtask
    task automatic t_coarse_multi(); run_req(2'b11, 1'b0, 1'b1, 3, 1'b0); endtask
    task automatic t_zero();         run_req(2'b01, 1'b0, 1'b0, 0, 1'b0); endtask
    task automatic t_busy_poke();    run_req(2'b10, 1'b0, 1'b0, 2, 1'b1); endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fine_single();
        t_fine_multi();
        t_coarse_single();
        t_coarse_multi();
        t_zero();
        t_busy_poke();
        t_coarse_multi();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2ms;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule